// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers five event sources of a motor-driver companion chip into one interrupt request. The sources are a falling edge on the LIN bus line, a high-temperature condition, a supply undervoltage, a supply overvoltage and an overcurrent. Each event latches a sticky flag. Software clears a flag by writing a one to its bit. An enable register gates each flag, and the enabled flags are combined into a single registered request line.

The block also drives a shutdown line for the high-side bridge switches. This line follows the undervoltage and overvoltage condition inputs directly, whatever the enable bits hold. The switches therefore come back on once the supply returns to its working range.

Registers are reached through a simple synchronous port with an address, write data, a write strobe and combinational read data. The serial transport that feeds this port is outside the block. So are the analog comparators that produce the condition levels.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the flag register and the enable register both read 0x00, and `irq` is low.
- R2: The flag register is at address 0x05. Its bits are: bit 5 LIN edge, bit 4 high temperature, bit 3 undervoltage, bit 2 overvoltage, bit 1 overcurrent. Bits 7, 6 and 0 always read 0.
- R3: Writing to address 0x05 clears every flag whose write-data bit is 1. A 0 bit leaves its flag unchanged.
- R4: The LIN flag is set by a high-to-low transition of `lin_rx` after a two-stage synchronizer. The flag reads 1 on the third rising edge after the low level is first sampled. A steady low level does not set the flag again after a clear.
- R5: While `temp_hi` is high, a write of 1 to bit 4 of address 0x05 does not clear the high-temperature flag.
- R6: Each condition input (`temp_hi`, `supply_lo`, `supply_hi`, `ovc`) that is high at a rising edge sets its flag at that edge. A set in the same cycle as a clear write wins, so the flag stays set.
- R7: The enable register is at address 0x04, with bits in the same positions as the flags. Only bits 5 to 1 are stored, and the other bits read 0.
- R8: `irq` is registered. After each rising edge it equals the OR, over bits 5 to 1, of flag AND enable as they stood before that edge.
- R9: `hs_off` is high in any cycle in which `supply_lo` or `supply_hi` is high, and low otherwise, independent of flags and enables.
- R10: Writes to any other address change nothing, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Read data for `addr`, combinational |
| lin_rx | input | 1 | Raw LIN bus line, asynchronous |
| temp_hi | input | 1 | High-temperature condition level |
| supply_lo | input | 1 | Supply undervoltage condition level |
| supply_hi | input | 1 | Supply overvoltage condition level |
| ovc | input | 1 | Overcurrent condition level |
| irq | output | 1 | Combined interrupt request, registered |
| hs_off | output | 1 | High-side bridge switch shutdown |

## Verification
The critical collision is a clear write to the flag register landing in the same cycle as a set event for the same bit. This happens either through a condition input that is still high, or through a LIN falling edge emerging from the synchronizer. The bench provokes it in two ways. It holds `temp_hi` or `ovc` high across a clear write. It also runs a long stretch of random writes alongside random condition and LIN activity. A behavioural model applies set-over-clear ordering, and the flags, `irq` and `hs_off` are compared against that model on every clock.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC = 2,
  parameter logic [AW-1:0] EN_ADDR = 8'h04,
  parameter logic [AW-1:0] FLAG_ADDR = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  output logic [DW-1:0] rdata,
  input  logic          lin_rx,
  input  logic          temp_hi,
  input  logic          supply_lo,
  input  logic          supply_hi,
  input  logic          ovc,
  output logic          irq,
  output logic          hs_off
);
  localparam int LIN_B = 5;
  localparam int HT_B  = 4;
  localparam int LV_B  = 3;
  localparam int HV_B  = 2;
  localparam int OC_B  = 1;
  localparam logic [DW-1:0] MASK = DW'((1 << (LIN_B + 1)) - (1 << OC_B));

  logic [SYNC:0]   lin_pipe;
  logic [DW-1:0]   flags, enables, set_vec, clr_vec;
  logic            lin_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lin_pipe <= '1;
    else        lin_pipe <= {lin_pipe[SYNC-1:0], lin_rx};

  assign lin_fall = lin_pipe[SYNC] & ~lin_pipe[SYNC-1];

  always_comb begin
    set_vec        = '0;
    set_vec[LIN_B] = lin_fall;
    set_vec[HT_B]  = temp_hi;
    set_vec[LV_B]  = supply_lo;
    set_vec[HV_B]  = supply_hi;
    set_vec[OC_B]  = ovc;
  end

  assign clr_vec = (wr_en && addr == FLAG_ADDR) ? (wdata & MASK) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= ((flags & ~clr_vec) | set_vec) & MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         enables <= '0;
    else if (wr_en && addr == EN_ADDR)  enables <= wdata & MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & enables);

  assign hs_off = supply_lo | supply_hi;

  always_comb
    if (addr == FLAG_ADDR)    rdata = flags;
    else if (addr == EN_ADDR) rdata = enables;
    else                      rdata = '0;
endmodule

module irq_flag_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] FLAG_ADDR = 8'h05
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          wr_en,
  input logic          temp_hi,
  input logic          supply_lo,
  input logic          supply_hi,
  input logic          ovc,
  input logic [DW-1:0] flags,
  input logic [DW-1:0] enables,
  input logic          irq,
  input logic          hs_off
);
  AST_HT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == FLAG_ADDR && wdata[4] && temp_hi) |=> flags[4]); // R5
  AST_OVC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovc |=> flags[1]); // R6
  AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == FLAG_ADDR && !wdata[3] && flags[3]) |=> flags[3]); // R3
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    |(flags & enables) |=> irq); // R8
  AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_lo || supply_hi) |-> hs_off); // R9
  AST_PAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[7:6] == 2'b00 && flags[0] == 1'b0 && enables[0] == 1'b0)); // R2
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.AW(AW), .DW(DW), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .temp_hi(temp_hi), .supply_lo(supply_lo), .supply_hi(supply_hi), .ovc(ovc),
  .flags(flags), .enables(enables), .irq(irq), .hs_off(hs_off)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic wr_en = 0, lin_rx = 1, temp_hi = 0, supply_lo = 0, supply_hi = 0, ovc = 0;
  logic irq, hs_off;
  int checks = 0, errors = 0;
  string phase = "R1";

  irq_flag_ctrl dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .lin_rx(lin_rx), .temp_hi(temp_hi), .supply_lo(supply_lo),
    .supply_hi(supply_hi), .ovc(ovc), .irq(irq), .hs_off(hs_off));

  always #4 clk = ~clk;

  // behavioural reference
  int lin_hist[$];
  bit [7:0] m_flag = 0, m_en = 0;
  bit m_irq = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_irq = 0; lin_hist = {1, 1, 1};
    end else begin
      bit fall;
      bit [7:0] nf;
      m_irq = (m_flag & m_en) != 0;
      fall = (lin_hist[0] == 1) && (lin_hist[1] == 0);
      nf = m_flag;
      if (wr_en && addr == 8'h05) nf = nf & ~wdata;
      if (wr_en && addr == 8'h04) m_en = wdata & 8'h3E;
      if (fall) nf[5] = 1;
      if (temp_hi) nf[4] = 1;
      if (supply_lo) nf[3] = 1;
      if (supply_hi) nf[2] = 1;
      if (ovc) nf[1] = 1;
      m_flag = nf & 8'h3E;
      void'(lin_hist.pop_front());
      lin_hist.push_back(int'(lin_rx));
    end
  end

  function automatic bit [7:0] m_read(bit [7:0] a);
    return a == 8'h05 ? m_flag : a == 8'h04 ? m_en : 8'h00;
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    chk("rdata", rdata, m_read(addr));
    chk("irq", {7'b0, irq}, {7'b0, m_irq});
    chk("hs_off", {7'b0, hs_off}, {7'b0, supply_lo | supply_hi});
  endtask

  task automatic wr(bit [7:0] a, bit [7:0] d);
    addr = a; wdata = d; wr_en = 1; cyc(); wr_en = 0;
  endtask

  task automatic rd(bit [7:0] a, bit [7:0] exp, string tag);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  initial begin
    #5000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    phase = "R1";
    rd(8'h05, 8'h00, "R1 flags"); rd(8'h04, 8'h00, "R1 enables");
    chk("R1 irq", {7'b0, irq}, 8'h00);

    phase = "R2";
    ovc = 1; cyc(); ovc = 0; supply_hi = 1; cyc(); supply_hi = 0;
    rd(8'h05, 8'h06, "R2 ovc+hv bits");
    wr(8'h05, 8'hFF); rd(8'h05, 8'h00, "R2 cleared");

    phase = "R3";
    supply_lo = 1; temp_hi = 1; cyc(); supply_lo = 0; temp_hi = 0; cyc();
    wr(8'h05, 8'h00); rd(8'h05, 8'h18, "R3 write zero keeps");
    wr(8'h05, 8'h08); rd(8'h05, 8'h10, "R3 clear lv only");

    phase = "R5";
    temp_hi = 1; cyc();
    wr(8'h05, 8'h10); rd(8'h05, 8'h10, "R5 ht kept");
    temp_hi = 0; cyc();
    wr(8'h05, 8'h10); rd(8'h05, 8'h00, "R5 ht cleared");

    phase = "R6";
    ovc = 1; wr(8'h05, 8'h02); rd(8'h05, 8'h02, "R6 set wins");
    ovc = 0; wr(8'h05, 8'h02); rd(8'h05, 8'h00, "R6 cleared");

    phase = "R4";
    lin_rx = 0; cyc(); cyc(); rd(8'h05, 8'h00, "R4 not yet");
    cyc(); rd(8'h05, 8'h20, "R4 edge flagged");
    wr(8'h05, 8'h20); repeat (5) cyc(); rd(8'h05, 8'h00, "R4 level ignored");
    lin_rx = 1; repeat (4) cyc(); rd(8'h05, 8'h00, "R4 rising ignored");

    phase = "R7";
    wr(8'h04, 8'hFF); rd(8'h04, 8'h3E, "R7 enable mask");

    phase = "R8";
    wr(8'h04, 8'h02); ovc = 1; cyc(); ovc = 0;
    chk("R8 irq one cycle lag", {7'b0, irq}, 8'h00);
    cyc(); chk("R8 irq up", {7'b0, irq}, 8'h01);
    wr(8'h05, 8'h02); cyc(); chk("R8 irq down", {7'b0, irq}, 8'h00);

    phase = "R9";
    wr(8'h04, 8'h00); supply_lo = 1; cyc();
    chk("R9 hs_off lo", {7'b0, hs_off}, 8'h01);
    supply_lo = 0; supply_hi = 1; cyc(); supply_hi = 0; cyc();
    chk("R9 hs_off release", {7'b0, hs_off}, 8'h00);
    wr(8'h05, 8'hFF);

    phase = "R10";
    wr(8'h07, 8'hFF); wr(8'h03, 8'hFF);
    rd(8'h07, 8'h00, "R10 other read"); rd(8'h04, 8'h00, "R10 en untouched");
    rd(8'h05, 8'h00, "R10 flags untouched");

    phase = "R6";
    for (int i = 0; i < 2000; i++) begin
      addr = ($urandom % 4) + 8'h03; wdata = 8'($urandom);
      wr_en = ($urandom % 3) == 0;
      lin_rx = ($urandom % 4) != 0; temp_hi = ($urandom % 6) == 0;
      supply_lo = ($urandom % 8) == 0; supply_hi = ($urandom % 8) == 0;
      ovc = ($urandom % 7) == 0;
      cyc();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule